// File: doc/BRIEF.md
# Four-Slot Rotating Transmit Descriptor Engine

This block holds four fixed transmit slots in its own register space. There is no descriptor list in memory. Each slot pairs a buffer base address with a command/status word. Software arms a slot by writing a byte count into that slot's command word. The engine then reads that many bytes, one after another, from a single contiguous buffer through a simple memory read port, and pushes each byte into a transmit FIFO.

When a slot finishes, the engine hands the slot back to software. It marks the slot as good or aborted and raises a completion or error flag in an interrupt status register. An interrupt mask register gates those flags onto one interrupt line.

Slots are strictly used in rotation, both by software and by the engine. The block keeps a pointer to the next slot software must arm and a pointer to the next slot the engine will serve. A summary register gathers the ownership, good and aborted bits of all four slots into one word.

Top module: `txslot_engine`

## Requirements
- R1: After reset every slot is owned by software (own bit 1, good and abort bits 0), both pointers are 0, the interrupt status and mask registers are 0, and irq is low.
- R2: For slot i, the buffer base register is at byte address 0x20+4*i and the command/status word is at 0x10+4*i. The command/status word holds the count in bits 12:0, own in bit 13, good in bit 14 and abort in bit 15.
- R3: A write to the command word of the slot named by the software pointer, while that slot's own bit is 1, is accepted. It loads the count, clears own, good and abort, and advances the software pointer by one modulo 4.
- R4: A command-word write to any other slot, or to a slot whose own bit is 0, changes no slot and no pointer, and sets interrupt status bit 2 (misuse).
- R5: A transfer reads addresses base to base+count-1 in increasing order. Each byte is pushed with fifo_wr in the cycle after its read. No read is issued in a cycle where fifo_full is high.
- R6: When the last byte is pushed, or at once when the count is 0, the slot gets own=1 and good=1, interrupt status bit 0 is set, and the hardware pointer advances by one.
- R7: If mem_rd_err is high with a returned byte, that byte is not pushed and the transfer stops. The slot gets own=1 and abort=1, interrupt status bit 1 is set, and the hardware pointer advances.
- R8: The engine serves slots strictly in the order 0,1,2,3,0,... Both pointers wrap from 3 to 0.
- R9: The interrupt status register (0x30) is write-one-to-clear, and a bit being set in the same cycle wins over the clear. irq is the OR of status AND mask, and the mask is at 0x34 (bits 2:0).
- R10: The summary register at 0x38 holds the own bits of slots 3..0 in bits 3:0, the good bits in 7:4 and the abort bits in 11:8. The pointer register at 0x3C holds the hardware pointer in bits 1:0 and the software pointer in bits 5:4.
- R11: A write to a slot's buffer base register while that slot's own bit is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Masked interrupt |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 8 | Read byte, valid the cycle after the request |
| mem_rd_err | input | 1 | Error flag returned with the read byte |
| fifo_wr | output | 1 | FIFO push |
| fifo_data | output | 8 | FIFO push data |
| fifo_full | input | 1 | FIFO cannot accept a request this cycle |

## Verification
The main transfer is exercised with several patterns:
- A short packet with the FIFO always free, which shows the plain read-then-push rhythm.
- A longer packet started under a held and then toggling fifo_full, which separates stalling from dropping or repeating bytes.
- A packet whose fourth read returns an error, which shows that the abort stops the stream at the correct byte.
- A zero-length packet, which completes without any read.

Writes to the wrong slot and to a busy slot, and a second lap past slot 3, show that rejection leaves the state untouched and that the rotation wraps. A behavioural byte queue in the bench checks every FIFO push against the expected buffer contents on every clock.

// File: rtl/txslot_engine.sv
module txslot_engine #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic              mem_rd_err,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data,
  input  logic              fifo_full
);
  localparam int NS = 4;
  localparam int PW = 2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DAT} st_t;

  logic [ADDR_W-1:0] base [NS];
  logic [CNT_W-1:0]  cnt  [NS];
  logic [NS-1:0]     own, good, abt;
  logic [PW-1:0]     hw_ptr, sw_ptr;
  logic [2:0]        isr, imr;
  logic [CNT_W-1:0]  offs;
  st_t               st;

  wire [1:0] sel    = reg_addr[3:2];
  wire       wr_ok  = reg_wr && (reg_addr[1:0] == 2'b00);
  wire       st_hit = wr_ok && (reg_addr[5:4] == 2'b01);
  wire       ad_hit = wr_ok && (reg_addr[5:4] == 2'b10);
  wire       is_hit = wr_ok && (reg_addr == 6'h30);
  wire       im_hit = wr_ok && (reg_addr == 6'h34);
  wire       accept = st_hit && (sel == sw_ptr) && own[sel];

  wire busy_hw  = !own[hw_ptr];
  wire last_one = (offs + CNT_W'(1)) == cnt[hw_ptr];
  wire done_ok  = (st == S_IDLE && busy_hw && cnt[hw_ptr] == '0) ||
                  (st == S_DAT && !mem_rd_err && last_one);
  wire done_err = (st == S_DAT) && mem_rd_err;
  wire done     = done_ok || done_err;

  assign mem_rd_en   = (st == S_REQ) && !fifo_full;
  assign mem_rd_addr = base[hw_ptr] + ADDR_W'(offs);
  assign fifo_wr     = (st == S_DAT) && !mem_rd_err;
  assign fifo_data   = mem_rd_data;
  assign irq         = |(isr & imr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        base[i] <= '0;
        cnt[i]  <= '0;
      end
      own    <= '1;
      good   <= '0;
      abt    <= '0;
      hw_ptr <= '0;
      sw_ptr <= '0;
      isr    <= '0;
      imr    <= '0;
      offs   <= '0;
      st     <= S_IDLE;
    end else begin
      if (ad_hit && own[sel]) base[sel] <= reg_wdata[ADDR_W-1:0];
      if (accept) begin
        cnt[sel]  <= reg_wdata[CNT_W-1:0];
        own[sel]  <= 1'b0;
        good[sel] <= 1'b0;
        abt[sel]  <= 1'b0;
        sw_ptr    <= sw_ptr + 1'b1;
      end
      if (done) begin
        own[hw_ptr]  <= 1'b1;
        good[hw_ptr] <= done_ok;
        abt[hw_ptr]  <= done_err;
        hw_ptr       <= hw_ptr + 1'b1;
      end
      isr <= (isr & ~(is_hit ? reg_wdata[2:0] : 3'b000)) |
             {st_hit && !accept, done_err, done_ok};
      if (im_hit) imr <= reg_wdata[2:0];
      case (st)
        S_IDLE: if (busy_hw && !done) begin
          offs <= '0;
          st   <= S_REQ;
        end
        S_REQ: if (!fifo_full) st <= S_DAT;
        S_DAT: begin
          offs <= offs + CNT_W'(1);
          st   <= done ? S_IDLE : S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [31:0] summary;
  always_comb begin
    summary = '0;
    for (int i = 0; i < NS; i++) begin
      summary[i]        = own[i];
      summary[NS + i]   = good[i];
      summary[2*NS + i] = abt[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[5:4])
      2'b01: reg_rdata = 32'({abt[sel], good[sel], own[sel], cnt[sel]});
      2'b10: reg_rdata = 32'(base[sel]);
      2'b11: case (sel)
        2'd0: reg_rdata = 32'(isr);
        2'd1: reg_rdata = 32'(imr);
        2'd2: reg_rdata = summary;
        default: reg_rdata = 32'({sw_ptr, 2'b00, hw_ptr});
      endcase
      default: reg_rdata = '0;
    endcase
  end

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && sel != sw_ptr) |=> (sw_ptr == $past(sw_ptr) && isr[2]));

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_ptr != $past(hw_ptr)) |-> (hw_ptr == $past(hw_ptr) + 2'd1));

  p_push_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(mem_rd_en));

  p_read_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (fifo_wr || mem_rd_err || done));

  p_read_in_buffer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ((mem_rd_addr - base[hw_ptr]) < ADDR_W'(cnt[hw_ptr])));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 3'b000) |-> !irq);
endmodule

// File: tb/test_txslot_engine.sv
module test_txslot_engine;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq, mem_rd_en, fifo_wr, fifo_full = 0;
  logic [31:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = 0, fifo_data;
  logic        mem_rd_err = 0;
  logic [31:0] bad_addr = 32'hFFFF_FFFF;

  int checks = 0, errors = 0, full_viol = 0;
  logic [7:0] expq[$];

  always #(CLK_P/2) clk = ~clk;

  txslot_engine i_txslot_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_err(mem_rd_err), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .fifo_full(fifo_full));

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem_byte(mem_rd_addr);
      mem_rd_err  <= (mem_rd_addr == bad_addr);
    end else begin
      mem_rd_err  <= 1'b0;
    end
  end

  // reference byte stream compared on every clock (R5)
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      if (mem_rd_en && fifo_full) full_viol++;
      if (fifo_wr) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R5 unexpected push actual=%02h expected=none", fifo_data);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          if (fifo_data !== e) begin
            errors++;
            $display("FAIL R5 pushed byte actual=%02h expected=%02h", fifo_data, e);
          end
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 2000; n++) begin
      rd(6'h3C, v);
      if (v[1:0] == v[5:4]) break;
    end
    rd(6'h3C, v);
  endtask

  task automatic arm(int s, logic [31:0] b, int c, int nbytes);
    for (int k = 0; k < nbytes; k++) expq.push_back(mem_byte(b + k));
    wr(6'(6'h20 + 4*s), b);
    wr(6'(6'h10 + 4*s), 32'(c));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;

    rd(6'h38, v); chk("R1 summary after reset", v, 32'h00F);
    rd(6'h3C, v); chk("R1 pointers after reset", v, 32'h0);
    rd(6'h30, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);

    wr(6'h34, 32'h7);
    arm(0, 32'h100, 5, 5);
    rd(6'h20, v); chk("R2 base readback", v, 32'h100);
    rd(6'h3C, v); chk("R3 sw pointer advanced", 32'(v[5:4]), 32'h1);
    wait_idle();
    rd(6'h10, v); chk("R6 slot0 done", v, 32'h6005);
    rd(6'h30, v); chk("R6 ok flag", v, 32'h1);
    chk("R9 irq raised", 32'(irq), 32'h1);
    wr(6'h30, 32'h1);
    rd(6'h30, v); chk("R9 w1c clears", v, 32'h0);
    chk("R9 irq dropped", 32'(irq), 32'h0);

    wr(6'h1C, 32'h4);
    rd(6'h30, v); chk("R4 misuse flag", v, 32'h4);
    rd(6'h3C, v); chk("R4 sw pointer kept", 32'(v[5:4]), 32'h1);
    rd(6'h1C, v); chk("R4 slot3 untouched", v, 32'h2000);
    wr(6'h30, 32'h4);

    @(negedge clk); fifo_full = 1;
    arm(1, 32'h200, 20, 20);
    wr(6'h24, 32'h999);
    rd(6'h24, v); chk("R11 busy base write ignored", v, 32'h200);
    repeat (10) @(negedge clk);
    rd(6'h14, v); chk("R5 stalled while full", v, 32'h0014);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      fifo_full = (i % 3 == 0);
    end
    @(negedge clk); fifo_full = 0;
    wait_idle();
    rd(6'h14, v); chk("R6 slot1 done", v, 32'h6014);

    wr(6'h30, 32'h7);
    bad_addr = 32'h303;
    arm(2, 32'h300, 8, 3);
    wait_idle();
    rd(6'h18, v); chk("R7 slot2 aborted", v, 32'hA008);
    rd(6'h30, v); chk("R7 error flag", v, 32'h2);
    rd(6'h3C, v); chk("R7 hw pointer advanced", 32'(v[1:0]), 32'h3);
    bad_addr = 32'hFFFF_FFFF;

    arm(3, 32'h400, 0, 0);
    wait_idle();
    rd(6'h1C, v); chk("R6 zero count done", v, 32'h6000);
    rd(6'h3C, v); chk("R8 pointers wrapped", v, 32'h0);

    arm(0, 32'h500, 2, 2);
    wait_idle();
    rd(6'h10, v); chk("R8 second lap slot0", v, 32'h6002);
    rd(6'h3C, v); chk("R8 pointers after lap", v, 32'h11);

    rd(6'h38, v); chk("R10 summary", v, 32'h4BF);

    wr(6'h34, 32'h0);
    chk("R9 masked irq", 32'(irq), 32'h0);
    wr(6'h34, 32'h1);
    chk("R9 unmasked irq", 32'(irq), 32'h1);

    chk("R5 all bytes pushed", 32'(expq.size()), 32'h0);
    chk("R5 no read while full", 32'(full_viol), 32'h0);
    finish_run();
  end
endmodule